// File: doc/BRIEF.md
# Wide Cycle Counter with Low-Half Wrap Flag

This block keeps a free-running cycle count that is twice the width of a software word. A processor reads it one word at a time through a single read port. Each read is selected by a 3-bit modifier. Because the two halves are read in different cycles, the low half can wrap between the two reads. A sticky wrap flag records that event. Reading the low half clears the flag. Reading the high half can return the flag on a carry output, and software subtracts that carry from the high word to get a consistent wide value.

A read is requested by holding `rd_stb` high for one cycle, with `rd_mod` valid in the same cycle. The count and flag sampled are those of that cycle. The result appears on `rd_data`, `cy_out` and `cy_we` after the next rising edge. The port has no back-pressure: the reader must always accept the result, and a strobe may be issued on every cycle. The read data and carry hold their values until a later read replaces them.

Top module: `wide_cycle_counter`

## Requirements
- R1: The count is CNT_W bits (default 64). Reset sets it to zero, and it then increases by one on every clock, modulo 2^CNT_W.
- R2: The wrap flag becomes set on the edge where count bit CNT_W/2-1 falls from 1 to 0, i.e. when the low half passes from all ones to zero.
- R3: A strobe with modifier 000 is a low read. The next cycle shows count bits CNT_W/2-1:0 on `rd_data`, and the read clears the wrap flag.
- R4: When a low read and a low-half wrap fall on the same edge, the flag ends up set.
- R5: A strobe with modifier bits [1:0] = 01 is a high read. The next cycle shows count bits CNT_W-1:CNT_W/2 on `rd_data`.
- R6: A high read with modifier bit 2 set (101) pulses `cy_we` for exactly one cycle. In that cycle `cy_out` equals the flag value of the strobe cycle. The flag itself is not changed.
- R7: A high read with modifier bit 2 clear (001) keeps `cy_we` low, leaves `cy_out` and the flag unchanged, and still updates `rd_data`.
- R8: Strobes with modifiers 010, 011, 100, 110 or 111 are ignored. `rd_data`, `cy_out` and the flag keep their values, and `cy_we` stays low.
- R9: While reset is asserted, `rd_data`, `cy_out` and `cy_we` are zero and the flag is clear.
- R10: Software does a low read, and then a 101 high read less than 2^(CNT_W/2) cycles later. The high word minus `cy_out` then equals the high half as it was in the cycle of the low read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the count advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read request, valid for one cycle |
| rd_mod | input | 3 | Read modifier: 000 low read, 001 high read, 101 high read with carry |
| rd_data | output | CNT_W/2 | Selected half of the count, one cycle after the strobe |
| cy_out | output | 1 | Wrap flag reported by a carry high read |
| cy_we | output | 1 | One-cycle pulse marking a carry write-back |

## Verification
The bound checker watches the following on every cycle:
- the count steps by one each cycle;
- every low-half wrap sets the flag;
- a low read clears the flag unless a wrap falls on the same edge;
- the data returned by low and high reads;
- the carry pulse and its value;
- the hold behaviour for 001 reads and for ignored modifiers.

Only the bench scenarios can show the software-level result. They place a low read just before a wrap and a carry high read just after it, so the corrected wide value can be checked. The same-edge collision is covered by a low read issued exactly at the all-ones low half. Sequences of 001 reads and ignored modifiers followed by a carry read show that the flag survived them.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_LO   = 2'd1,
    RD_HI   = 2'd2
  } rd_kind_e;

  typedef struct packed {
    rd_kind_e kind;
    logic     cy_wr;
  } rd_req_t;

  localparam int unsigned MOD_W = 3;

  localparam logic [1:0] SEL_LO = 2'b00;
  localparam logic [1:0] SEL_HI = 2'b01;

  // Map a modifier field onto a read request.
  function automatic rd_req_t decode_mod(input logic [MOD_W-1:0] m);
    rd_req_t r;
    r.kind  = RD_NONE;
    r.cy_wr = 1'b0;
    if (m[1:0] == SEL_LO && !m[2]) begin
      r.kind = RD_LO;
    end else if (m[1:0] == SEL_HI) begin
      r.kind  = RD_HI;
      r.cy_wr = m[2];
    end
    return r;
  endfunction

endpackage

// File: rtl/wcc_count.sv
module wcc_count #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             lo_wrap
);
  localparam int unsigned NSEG   = CNT_W / SEG_W;
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [NSEG:0] carry;
  assign carry[0] = 1'b1;

  // Segmented incrementer: each slice advances when every slice below is all ones.
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W-1:0] seg_q;

    assign carry[g+1] = carry[g] & (&seg_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q <= '0;
      end else begin
        seg_q <= seg_q + {{(SEG_W-1){1'b0}}, carry[g]};
      end
    end

    assign cnt[g*SEG_W +: SEG_W] = seg_q;
  end

  // The low half rolls over on the next edge.
  assign lo_wrap = &cnt[HALF_W-1:0];

endmodule

// File: rtl/wcc_wrap_flag.sv
module wcc_wrap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_wrap,
  input  logic lo_clr,
  output logic flag
);
  // A wrap takes priority over a clear on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (lo_wrap) begin
      flag <= 1'b1;
    end else if (lo_clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wcc_read_port.sv
module wcc_read_port
  import wcc_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  rd_req_t              req,
  input  logic [CNT_W-1:0]     cnt,
  input  logic                 flag,
  output logic [CNT_W/2-1:0]   rd_data,
  output logic                 cy_out,
  output logic                 cy_we
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic hi_cy;
  assign hi_cy = stb && (req.kind == RD_HI) && req.cy_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      cy_out  <= 1'b0;
      cy_we   <= 1'b0;
    end else begin
      cy_we <= hi_cy;
      if (hi_cy) begin
        cy_out <= flag;
      end
      if (stb) begin
        case (req.kind)
          RD_LO:   rd_data <= cnt[HALF_W-1:0];
          RD_HI:   rd_data <= cnt[CNT_W-1:HALF_W];
          default: rd_data <= rd_data;
        endcase
      end
    end
  end
endmodule

// File: rtl/wide_cycle_counter.sv
module wide_cycle_counter
  import wcc_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic [2:0]         rd_mod,
  output logic [CNT_W/2-1:0] rd_data,
  output logic               cy_out,
  output logic               cy_we
);
  logic [CNT_W-1:0] cnt_q;
  logic             lo_wrap;
  logic             flag_q;
  rd_req_t          req;
  logic             lo_clr;

  assign req    = decode_mod(rd_mod);
  assign lo_clr = rd_stb && (req.kind == RD_LO);

  wcc_count #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_q),
    .lo_wrap (lo_wrap)
  );

  wcc_wrap_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_wrap (lo_wrap),
    .lo_clr  (lo_clr),
    .flag    (flag_q)
  );

  wcc_read_port #(.CNT_W(CNT_W)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (rd_stb),
    .req     (req),
    .cnt     (cnt_q),
    .flag    (flag_q),
    .rd_data (rd_data),
    .cy_out  (cy_out),
    .cy_we   (cy_we)
  );
endmodule

// File: rtl/wide_cycle_counter_chk.sv
module wide_cycle_counter_chk #(
  parameter int unsigned CNT_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_stb,
  input logic [2:0]         rd_mod,
  input logic [CNT_W-1:0]   cnt,
  input logic               flag,
  input logic [CNT_W/2-1:0] rd_data,
  input logic               cy_out,
  input logic               cy_we
);
  localparam int unsigned H = CNT_W / 2;

  logic wrap, lo_rd, hi_rd, hi_cy, keep;
  assign wrap  = &cnt[H-1:0];
  assign lo_rd = rd_stb && (rd_mod == 3'b000);
  assign hi_rd = rd_stb && (rd_mod[1:0] == 2'b01);
  assign hi_cy = rd_stb && (rd_mod == 3'b101);
  assign keep  = !rd_stb || (rd_mod[1] == 1'b1) || (rd_mod == 3'b100);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));

  assert_wrap_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);

  assert_low_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && !wrap) |=> !flag);

  assert_low_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> (rd_data == $past(cnt[H-1:0])));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && wrap) |=> flag);

  assert_high_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> (rd_data == $past(cnt[CNT_W-1:H])));

  assert_carry_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cy |=> (cy_we && (cy_out == $past(flag))));

  assert_no_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_cy |=> (!cy_we && $stable(cy_out)));

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !lo_rd) |=> $stable(flag));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> $stable(rd_data));

endmodule

bind wide_cycle_counter wide_cycle_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_stb  (rd_stb),
  .rd_mod  (rd_mod),
  .cnt     (cnt_q),
  .flag    (flag_q),
  .rd_data (rd_data),
  .cy_out  (cy_out),
  .cy_we   (cy_we)
);

// File: tb/wide_cycle_counter_test.sv
`timescale 1ns/1ps
module wide_cycle_counter_test;
  localparam int unsigned CW = 24;
  localparam int unsigned SW = 8;
  localparam int unsigned H  = CW / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_stb = 1'b0;
  logic [2:0]   rd_mod = 3'b000;
  logic [H-1:0] rd_data;
  logic         cy_out;
  logic         cy_we;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wide_cycle_counter #(.CNT_W(CW), .SEG_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_mod(rd_mod),
    .rd_data(rd_data), .cy_out(cy_out), .cy_we(cy_we)
  );

  // Reference model built from the requirements.
  logic [CW-1:0] m_cnt;
  logic          m_flag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  <= '0;
      m_flag <= 1'b0;
    end else begin
      m_cnt <= m_cnt + 1'b1;
      if (&m_cnt[H-1:0])                    m_flag <= 1'b1;
      else if (rd_stb && rd_mod == 3'b000)  m_flag <= 1'b0;
    end
  end

  typedef struct {
    logic [H-1:0] data;
    logic         we;
    logic         cy;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [H-1:0] last_data = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Driver: call at a falling edge; returns at the next falling edge.
  task automatic do_read(input logic [2:0] mod, input string tag);
    exp_t e;
    e.tag = tag;
    e.we  = 1'b0;
    e.cy  = 1'b0;
    if (mod == 3'b000) begin
      e.data = m_cnt[H-1:0];
    end else if (mod[1:0] == 2'b01) begin
      e.data = m_cnt[CW-1:H];
      e.we   = mod[2];
      e.cy   = m_flag;
    end else begin
      e.data = last_data;
    end
    last_data = e.data;
    sb.push_back(e);
    rd_stb = 1'b1;
    rd_mod = mod;
    @(negedge clk);
    rd_stb = 1'b0;
    rd_mod = 3'b000;
  endtask

  // Monitor: compare each result one step after the capturing edge.
  always @(posedge clk) begin
    if (rst_n && rd_stb) begin
      exp_t e;
      #1;
      if (sb.size() == 0) begin
        check("scoreboard-empty", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        check({e.tag, " data"}, 32'(rd_data), 32'(e.data));
        check({e.tag, " cy_we"}, 32'(cy_we), 32'(e.we));
        if (e.we) check({e.tag, " cy_out"}, 32'(cy_out), 32'(e.cy));
      end
    end
  end

  task automatic wait_lo(input logic [H-1:0] v);
    while (m_cnt[H-1:0] != v) @(negedge clk);
  endtask

  logic [H-1:0] hi_at_lo;

  initial begin
    // R9: reset values
    repeat (3) @(negedge clk);
    check("R9 rd_data", 32'(rd_data), 32'd0);
    check("R9 cy_out", 32'(cy_out), 32'd0);
    check("R9 cy_we", 32'(cy_we), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R3/R5/R6: first reads after reset, flag clear
    do_read(3'b000, "R1 low after reset");
    do_read(3'b101, "R6 carry clear");
    repeat (37) @(negedge clk);
    do_read(3'b000, "R1 low after gap");
    do_read(3'b001, "R7 high no carry");
    do_read(3'b001, "R5 high");

    // R8: ignored modifiers
    do_read(3'b010, "R8 mod 010");
    do_read(3'b011, "R8 mod 011");
    do_read(3'b100, "R8 mod 100");
    do_read(3'b110, "R8 mod 110");
    do_read(3'b111, "R8 mod 111");

    // R2/R10: low read just before a wrap, carry read after it
    wait_lo({{(H-1){1'b1}}, 1'b0});
    hi_at_lo = m_cnt[CW-1:H];
    do_read(3'b000, "R3 low before wrap");
    @(negedge clk);
    do_read(3'b101, "R2 carry after wrap");
    check("R2 carry set", 32'(cy_out), 32'd1);
    check("R10 corrected high", 32'(rd_data - H'(cy_out)), 32'(hi_at_lo));

    // R7/R8: flag survives 001 reads and ignored modifiers
    do_read(3'b001, "R7 high keeps flag");
    do_read(3'b110, "R8 ignored keeps flag");
    do_read(3'b101, "R7 flag still set");
    check("R7 flag survived", 32'(cy_out), 32'd1);

    // R3: low read clears
    do_read(3'b000, "R3 clearing low");
    do_read(3'b101, "R3 flag cleared");
    check("R3 flag cleared", 32'(cy_out), 32'd0);

    // R4: low read on the all-ones edge; set wins
    wait_lo({H{1'b1}});
    hi_at_lo = m_cnt[CW-1:H];
    do_read(3'b000, "R4 low at all ones");
    check("R4 low data", 32'(rd_data), 32'({H{1'b1}}));
    do_read(3'b101, "R4 set wins");
    check("R4 carry set", 32'(cy_out), 32'd1);
    check("R10 corrected high at edge", 32'(rd_data - H'(cy_out)), 32'(hi_at_lo));

    // R10: no wrap between the reads
    wait_lo(H'(256));
    hi_at_lo = m_cnt[CW-1:H];
    do_read(3'b000, "R10 low mid");
    do_read(3'b101, "R10 carry mid");
    check("R10 no correction", 32'(rd_data - H'(cy_out)), 32'(hi_at_lo));

    // R6: single-cycle pulse
    @(negedge clk);
    check("R6 pulse ended", 32'(cy_we), 32'd0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule